// File: doc/BRIEF.md
# Parallel Code-Flash Programming Controller

This block models the parallel programming path of a small on-chip code flash. An external programmer places a byte address and a data byte on the block's inputs, selects an operation with a four-bit mode selector, and strobes an active-low program pulse. The block then runs byte programming, lock-bit programming or whole-array erase against a register-array model of the flash. It also serves read-back for verification and returns three fixed identification bytes.

A byte write is self-timed. The cycle count is derived from a clock frequency parameter and a duration in microseconds. While the write runs, a ready flag stays low. Reading the byte under write returns its top bit inverted, so software can poll for completion. Programming can only clear bits. Bits return to 1 only through an erase, and the erase runs only if the program pulse was held low for at least the erase duration. When both lock bits are set, verify reads of the array are blocked.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `err` is 0, both lock bits are clear and every array byte reads FFH in verify mode (`mode_sel` = 4'b0011).
- R2: In program mode (`mode_sel` = 4'b0111) with `hv_en` high, the first clock edge that samples `prog_n` high after a low sample starts a write. `ready` then reads 0 for exactly WRITE_CYC = CLK_KHZ*WRITE_US/1000 cycles and returns to 1 on the following edge.
- R3: A completed code write stores the bitwise AND of the old byte and the written byte, so only 1 bits can become 0.
- R4: While a code write is busy, a verify read at the address being written returns the written byte with bit 7 inverted. Once the write completes, the same read returns the stored value.
- R5: A program-pulse rise that arrives while busy is ignored: the array is unchanged and the running write keeps its length. It sets `err`, which stays 1 until reset.
- R6: In erase mode (`mode_sel` = 4'b1001) with `hv_en` high, a rise that follows at least ERASE_CYC = CLK_KHZ*ERASE_US/1000 consecutive low samples of `prog_n` sets every byte to FFH and clears both lock bits. `ready` stays 1 throughout.
- R7: An erase rise that follows fewer than ERASE_CYC low samples changes nothing.
- R8: In signature mode (`mode_sel` = 4'b0000), address 030H reads 1EH, 031H reads 51H, and 032H reads FFH when HV12 = 1 or 05H when HV12 = 0. Any other address reads FFH. Lock bits have no effect on these reads.
- R9: Lock-bit programming (`mode_sel` = 4'b1111 for lock 1, 4'b1110 for lock 2) is a timed write like R2. With only one lock bit set, verify reads are normal. With both set, verify reads return FFH.
- R10: With `hv_en` low, program, lock and erase pulses are ignored: `ready` stays 1, nothing changes and `err` is not set.
- R11: In any mode value not listed above, `rd_data` reads FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data byte to program |
| mode_sel | input | 4 | Operation select |
| prog_n | input | 1 | Active-low program / erase pulse |
| hv_en | input | 1 | Programming voltage present |
| rd_data | output | 8 | Verify, polling or signature read data |
| ready | output | 1 | 1 when no timed write is running |
| err | output | 1 | Sticky flag: a pulse arrived while busy |

## Verification
The bench builds the block with ADDR_W = 6, CLK_KHZ = 10, WRITE_US = 1500 and ERASE_US = 10000. This gives a 64-byte array, a 15-cycle write and a 100-cycle erase threshold. The 64 bytes still cover the three signature addresses. At this size every address can be written twice with arithmetic patterns and read back completely after each phase. The short timings put the exact end of the busy window and the erase width one below the threshold and at it within a few thousand cycles.

// File: rtl/fl_pkg.sv
package fl_pkg;

    localparam logic [3:0] MODE_SIG    = 4'b0000;
    localparam logic [3:0] MODE_VERIFY = 4'b0011;
    localparam logic [3:0] MODE_PROG   = 4'b0111;
    localparam logic [3:0] MODE_LOCK1  = 4'b1111;
    localparam logic [3:0] MODE_LOCK2  = 4'b1110;
    localparam logic [3:0] MODE_ERASE  = 4'b1001;

    localparam logic [7:0] SIG_MAKER   = 8'h1E;
    localparam logic [7:0] SIG_DEVICE  = 8'h51;
    localparam logic [7:0] SIG_VPP12   = 8'hFF;
    localparam logic [7:0] SIG_VPP5    = 8'h05;

    typedef enum logic [1:0] {
        WK_CODE  = 2'd0,
        WK_LOCK1 = 2'd1,
        WK_LOCK2 = 2'd2
    } wr_kind_e;

    typedef struct packed {
        logic l1;
        logic l2;
    } lock_t;

endpackage

// File: rtl/fl_pulse_timer.sv
module fl_pulse_timer #(
    parameter int LOW_MAX = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n,
    output logic rise,
    output logic long_low
);
    localparam int LW = $clog2(LOW_MAX + 1);

    typedef struct packed {
        logic          prog;
        logic [LW-1:0] low;
    } pt_t;

    pt_t q, d;

    always_comb begin
        d.prog = prog_n;
        if (prog_n)
            d.low = '0;
        else if (q.low == LW'(LOW_MAX))
            d.low = q.low;
        else
            d.low = q.low + 1'b1;
    end

    assign rise     = prog_n & ~q.prog;
    assign long_low = (q.low == LW'(LOW_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prog <= 1'b1;
            q.low  <= '0;
        end else begin
            q <= d;
        end
    end

    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (q.low != '0)); // R6

endmodule

// File: rtl/fl_seq.sv
module fl_seq
    import fl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WRITE_CYC = 18000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              long_low,
    input  logic [3:0]        mode_sel,
    input  logic              hv_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              busy,
    output logic              err,
    output logic              wr_en,
    output wr_kind_e          wr_kind,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              erase_en
);
    localparam int CW = (WRITE_CYC > 1) ? $clog2(WRITE_CYC) : 1;

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        wr_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              err;
    } seq_t;

    seq_t q, d;
    logic start;
    wr_kind_e start_kind;

    always_comb begin
        start      = 1'b0;
        start_kind = WK_CODE;
        erase_en   = 1'b0;
        if (!q.busy && rise && hv_en) begin
            case (mode_sel)
                MODE_PROG:  start = 1'b1;
                MODE_LOCK1: begin start = 1'b1; start_kind = WK_LOCK1; end
                MODE_LOCK2: begin start = 1'b1; start_kind = WK_LOCK2; end
                MODE_ERASE: erase_en = long_low;
                default:    ;
            endcase
        end
    end

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                wr_en  = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            if (rise)
                d.err = 1'b1;
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = CW'(WRITE_CYC - 1);
            d.kind = start_kind;
            d.addr = addr;
            d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, cnt: '0, kind: WK_CODE, addr: '0, data: 8'h00, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy    = q.busy;
    assign err     = q.err;
    assign wr_kind = q.kind;
    assign wr_addr = q.addr;
    assign wr_data = q.data;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != '0) |=> q.busy); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err); // R5
    AST_BUSY_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && rise) |=> q.err); // R5
    AST_HV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !hv_en) |=> !q.busy); // R10

endmodule

// File: rtl/fl_store.sv
module fl_store
    import fl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_kind_e          wr_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    output logic              locked
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];
    lock_t lk_q, lk_d;

    always_comb begin
        lk_d = lk_q;
        if (erase_en) begin
            lk_d = '0;
        end else if (wr_en) begin
            if (wr_kind == WK_LOCK1) lk_d.l1 = 1'b1;
            if (wr_kind == WK_LOCK2) lk_d.l2 = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            lk_q <= lk_d;
            if (erase_en) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            end else if (wr_en && wr_kind == WK_CODE) begin
                mem_q[wr_addr] <= mem_q[wr_addr] & wr_data;
            end
        end
    end

    assign rd_byte = mem_q[rd_addr];
    assign locked  = lk_q.l1 & lk_q.l2;

    AST_LOCK1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.l1 && !erase_en) |=> lk_q.l1); // R9
    AST_LOCK2_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.l2 && !erase_en) |=> lk_q.l2); // R9
    AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (!lk_q.l1 && !lk_q.l2)); // R6

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CLK_KHZ  = 12000,
    parameter int WRITE_US = 1500,
    parameter int ERASE_US = 10000,
    parameter bit HV12     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [3:0]        mode_sel,
    input  logic              prog_n,
    input  logic              hv_en,
    output logic [7:0]        rd_data,
    output logic              ready,
    output logic              err
);
    localparam int WRITE_CYC = CLK_KHZ * WRITE_US / 1000;
    localparam int ERASE_CYC = CLK_KHZ * ERASE_US / 1000;
    localparam logic [7:0] SIG_VPP = HV12 ? SIG_VPP12 : SIG_VPP5;

    logic              rise, long_low, busy, wr_en, erase_en, locked;
    wr_kind_e          wr_kind;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data, rd_byte, sig_byte;

    fl_pulse_timer #(.LOW_MAX(ERASE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n),
        .rise(rise), .long_low(long_low)
    );

    fl_seq #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .long_low(long_low),
        .mode_sel(mode_sel), .hv_en(hv_en), .addr(addr), .din(din),
        .busy(busy), .err(err), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .wr_data(wr_data), .erase_en(erase_en)
    );

    fl_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .wr_data(wr_data), .erase_en(erase_en),
        .rd_addr(addr), .rd_byte(rd_byte), .locked(locked)
    );

    always_comb begin
        if (addr == ADDR_W'(12'h030))      sig_byte = SIG_MAKER;
        else if (addr == ADDR_W'(12'h031)) sig_byte = SIG_DEVICE;
        else if (addr == ADDR_W'(12'h032)) sig_byte = SIG_VPP;
        else                               sig_byte = 8'hFF;
    end

    always_comb begin
        case (mode_sel)
            MODE_SIG: rd_data = sig_byte;
            MODE_VERIFY: begin
                if (busy && wr_kind == WK_CODE && addr == wr_addr)
                    rd_data = {~wr_data[7], wr_data[6:0]};
                else if (locked)
                    rd_data = 8'hFF;
                else
                    rd_data = rd_byte;
            end
            default: rd_data = 8'hFF;
        endcase
    end

    assign ready = ~busy;

    AST_NO_START_WITHOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rise) |=> ready); // R2

endmodule

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;
    localparam int CLK_NS = 10;
    localparam int AW     = 6;
    localparam int KHZ    = 10;
    localparam int WUS    = 1500;
    localparam int EUS    = 10000;
    localparam int WCYC   = KHZ * WUS / 1000;
    localparam int ECYC   = KHZ * EUS / 1000;
    localparam int N      = 1 << AW;

    localparam logic [3:0] M_SIG = 4'b0000, M_VER = 4'b0011, M_PRG = 4'b0111,
                           M_LK1 = 4'b1111, M_LK2 = 4'b1110, M_ERS = 4'b1001;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic [3:0]    mode_sel = 4'b0011;
    logic          prog_n = 1'b1, hv_en = 1'b1;
    logic [7:0]    rd_data;
    logic          ready, err;

    logic [7:0] model [N];
    bit   lk1, lk2, done;
    int   checks = 0, fails = 0;

    always #(CLK_NS/2) clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(AW), .CLK_KHZ(KHZ), .WRITE_US(WUS),
                      .ERASE_US(EUS), .HV12(1'b1)) i_flash_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode_sel(mode_sel),
        .prog_n(prog_n), .hv_en(hv_en), .rd_data(rd_data), .ready(ready), .err(err)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        prog_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) model[i] = 8'hFF;
        lk1 = 0; lk2 = 0;
        @(negedge clk);
    endtask

    task automatic verify_all(string req);
        @(negedge clk);
        mode_sel = M_VER;
        for (int a = 0; a < N; a++) begin
            addr = AW'(a);
            #1;
            chk(req, rd_data, (lk1 && lk2) ? 8'hFF : model[a]);
        end
    endtask

    task automatic do_write(logic [3:0] m, int a, logic [7:0] d);
        @(negedge clk);
        mode_sel = m; addr = AW'(a); din = d; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
        chk("R2 busy start", {7'd0, ready}, 8'd0);
        if (m == M_PRG) begin
            mode_sel = M_VER;
            #1;
            chk("R4 polling", rd_data, {~d[7], d[6:0]});
        end
        repeat (WCYC - 1) @(negedge clk);
        chk("R2 busy last", {7'd0, ready}, 8'd0);
        @(negedge clk);
        chk("R2 ready again", {7'd0, ready}, 8'd1);
        if (m == M_PRG) begin
            model[a] = model[a] & d;
            mode_sel = M_VER; addr = AW'(a);
            #1;
            chk("R4 true data", rd_data, model[a]);
        end
        if (m == M_LK1) lk1 = 1;
        if (m == M_LK2) lk2 = 1;
    endtask

    task automatic do_erase(int n, logic hv);
        @(negedge clk);
        mode_sel = M_ERS; hv_en = hv; prog_n = 1'b0;
        repeat (n) @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
        chk("R6 no busy on erase", {7'd0, ready}, 8'd1);
        if (n >= ECYC && hv) begin
            for (int i = 0; i < N; i++) model[i] = 8'hFF;
            lk1 = 0; lk2 = 0;
        end
        hv_en = 1'b1;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 ready", {7'd0, ready}, 8'd1);
        chk("R1 err", {7'd0, err}, 8'd0);
        verify_all("R1 blank");

        // R8 signature and R11 other modes
        mode_sel = M_SIG;
        addr = AW'(6'h30); #1; chk("R8 maker", rd_data, 8'h1E);
        addr = AW'(6'h31); #1; chk("R8 device", rd_data, 8'h51);
        addr = AW'(6'h32); #1; chk("R8 vpp", rd_data, 8'hFF);
        addr = AW'(6'h33); #1; chk("R8 other", rd_data, 8'hFF);
        mode_sel = 4'b0101; addr = AW'(2); #1; chk("R11 idle mode", rd_data, 8'hFF);

        // R3 two overlapping program passes
        for (int a = 0; a < N; a++) do_write(M_PRG, a, 8'((a * 37 + 5) & 8'hFF));
        verify_all("R3 first pass");
        for (int a = 0; a < N; a++) do_write(M_PRG, a, 8'(a) ^ 8'h5A);
        verify_all("R3 and pass");

        // R10 no high voltage
        @(negedge clk);
        hv_en = 1'b0; mode_sel = M_PRG; addr = AW'(9); din = 8'h00; prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1;
        @(negedge clk);
        chk("R10 ready stays", {7'd0, ready}, 8'd1);
        chk("R10 no err", {7'd0, err}, 8'd0);
        hv_en = 1'b1;
        do_erase(ECYC, 1'b0);
        verify_all("R10 unchanged");

        // R7 short erase, then R6 full erase
        do_erase(ECYC - 1, 1'b1);
        verify_all("R7 short erase");
        do_erase(ECYC, 1'b1);
        verify_all("R6 erased");

        // R9 locks
        do_write(M_PRG, 7, 8'h12);
        do_write(M_PRG, 40, 8'hA5);
        do_write(M_LK1, 0, 8'h00);
        verify_all("R9 one lock");
        do_write(M_LK2, 0, 8'h00);
        verify_all("R9 both locks");
        mode_sel = M_SIG; addr = AW'(6'h31); #1; chk("R8 sig while locked", rd_data, 8'h51);
        do_erase(ECYC, 1'b1);
        do_write(M_PRG, 3, 8'h3C);
        verify_all("R6 unlocked after erase");

        // R5 pulse while busy
        @(negedge clk);
        mode_sel = M_PRG; addr = AW'(5); din = 8'h00; prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1;
        @(negedge clk); addr = AW'(6); prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1;
        @(negedge clk);
        chk("R5 err set", {7'd0, err}, 8'd1);
        repeat (WCYC - 3) @(negedge clk);
        chk("R5 length kept busy", {7'd0, ready}, 8'd0);
        @(negedge clk);
        chk("R5 length kept ready", {7'd0, ready}, 8'd1);
        model[5] = 8'h00;
        do_write(M_PRG, 9, 8'hF0);
        chk("R5 err sticky", {7'd0, err}, 8'd1);
        verify_all("R5 ignored pulse");
        do_reset();
        chk("R5 err cleared by reset", {7'd0, err}, 8'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule